// File: doc/BRIEF.md
# Cache Invalidation Control Sequencer

This block is the control and status slice of a level-one cache together with a sequencer that wipes the whole cache. A small control word, written and read through a single register port, holds a lookup-enable bit, a set/way organization select, a start-invalidate bit and a sticky abort flag. When software writes a 1 to the start-invalidate bit while nothing is in progress, the sequencer steps through every set of the tag array. It visits one set per clock and drives a tag write port that marks all ways of that set invalid.

The walk length follows the organization bit. With the bit at 0 the cache is 128 sets of 8 ways. With the bit at 1 it is 256 sets of 4 ways. While a walk runs, the start-invalidate bit reads back as 1. It drops to 0 on its own when the last set has been written, and a one-cycle completion pulse marks that point. An external abort input can cut a walk short. The sequencer then returns to idle and latches the abort flag, which stays set until software writes 0 to it. The lookup-enable output gates ordinary load and store lookups only. Invalidation runs whatever its value.

The sequencer has three states. In IDLE no walk is running. An accepted start moves it to WALK. In WALK it stays while sets remain, leaves for DONE after the last set, and leaves for IDLE on an abort. DONE lasts one cycle and shows the completion pulse. From DONE it goes to WALK if a new start arrives in that cycle, and to IDLE otherwise. IDLE accepts a start the same way.

Top module: `cache_inval_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the control word reads 0, busy, done and tag write-enable are 0 and the lookup-enable output is 0.
- R2: Control-word layout is bit 0 lookup enable, bit 1 start-invalidate, bit 2 abort flag, bit 3 organization. A write with bit 1 set while no walk runs starts a walk. From the next cycle busy is 1, bit 1 reads 1, and the first set written is set 0.
- R3: Every walk cycle asserts tag write-enable. The set index rises by one each cycle, starting at 0. The way mask is 8'hFF when organization is 0 and 8'h0F when organization is 1.
- R4: A walk writes exactly 128 sets (organization 0) or 256 sets (organization 1). In the cycle after the last set, done is 1 for one cycle, busy is 0 and bit 1 reads 0.
- R5: While busy, writes have no effect on bit 1, whether they carry 0 or 1. The walk is neither stopped nor restarted.
- R6: The organization bit takes its written value only when no walk is in progress. While busy it holds its value.
- R7: Abort input high during a walk cycle suppresses that cycle's tag write. On the next cycle busy is 0, bit 1 reads 0, the abort flag reads 1, and no done pulse occurs. This holds on the last set too.
- R8: The abort flag is cleared only by a register write with bit 2 at 0. Writes with bit 2 at 1 leave it unchanged.
- R9: The lookup-enable output follows bit 0 of the control word, which takes every written value. Walks run and complete with bit 0 at either value.
- R10: Abort input high while no walk is in progress has no effect on the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 4 | Control-word write value |
| rd_data | output | 4 | Control-word read value |
| abort_in | input | 1 | Request to stop a running walk |
| lookup_en | output | 1 | Enable for normal load/store lookups |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse after a completed walk |
| tag_we | output | 1 | Tag array write enable |
| tag_set | output | 8 | Tag array set index |
| tag_mask | output | 8 | Ways whose valid bits are cleared |

## Verification
The walk is run in both organizations, with lookup enable both off and on, so that the set count and way mask are told apart per organization. Some walks are left quiet and others are flooded with register writes every cycle that carry start set and a flipped organization bit. A missing restart guard or organization guard therefore shows up as a broken index sequence or a wrong mask. Aborts are injected mid-walk, on the very last set and while idle, which separates abort from completion priority and confirms the flag only latches during a walk. A few fully random walks are run with a fixed seed and sparse random writes.

// File: rtl/cinv_pkg.sv
`timescale 1ns/1ps
package cinv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_DONE = 2'd2
    } walk_state_t;

    localparam int CTRL_W = 4;
    localparam int F_EN   = 0;
    localparam int F_INV  = 1;
    localparam int F_ABT  = 2;
    localparam int F_ORG  = 3;

endpackage

// File: rtl/cinv_regs.sv
`timescale 1ns/1ps
module cinv_regs
    import cinv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              busy,
    input  logic              abort_hit,
    output logic              en_q,
    output logic              org_q,
    output logic              abort_q,
    output logic              start,
    output logic [CTRL_W-1:0] rd_data
);

    logic soft_clr_abt;
    logic org_load;

    always_comb begin
        start        = wr_en && wr_data[F_INV] && !busy;
        soft_clr_abt = wr_en && !wr_data[F_ABT];
        org_load     = wr_en && !busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            org_q   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            if (wr_en) begin
                en_q <= wr_data[F_EN];
            end
            if (org_load) begin
                org_q <= wr_data[F_ORG];
            end
            if (abort_hit) begin
                abort_q <= 1'b1;
            end else if (soft_clr_abt) begin
                abort_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data        = '0;
        rd_data[F_EN]  = en_q;
        rd_data[F_INV] = busy;
        rd_data[F_ABT] = abort_q;
        rd_data[F_ORG] = org_q;
    end

    AST_START_SHOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> rd_data[F_INV]); // R2

    AST_ORG_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(org_q)); // R6

    AST_ABORT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        abort_hit |=> abort_q); // R7

    AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_q && !(wr_en && !wr_data[F_ABT])) |=> abort_q); // R8

endmodule

// File: rtl/cinv_walker.sv
`timescale 1ns/1ps
module cinv_walker
    import cinv_pkg::*;
#(
    parameter int SETS_ORG0 = 128,
    parameter int WAYS_ORG0 = 8,
    parameter int SETS_ORG1 = 256,
    parameter int WAYS_ORG1 = 4
)(
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        start,
    input  logic                                        org,
    input  logic                                        abort_in,
    output logic                                        busy,
    output logic                                        done,
    output logic                                        abort_hit,
    output logic                                        tag_we,
    output logic [$clog2((SETS_ORG0 > SETS_ORG1) ? SETS_ORG0 : SETS_ORG1)-1:0] tag_set,
    output logic [((WAYS_ORG0 > WAYS_ORG1) ? WAYS_ORG0 : WAYS_ORG1)-1:0]        tag_mask
);

    localparam int SETS_MAX = (SETS_ORG0 > SETS_ORG1) ? SETS_ORG0 : SETS_ORG1;
    localparam int WAYS_MAX = (WAYS_ORG0 > WAYS_ORG1) ? WAYS_ORG0 : WAYS_ORG1;
    localparam int SET_W    = $clog2(SETS_MAX);

    walk_state_t       state_q, state_d;
    logic [SET_W-1:0]  idx_q, idx_d;
    logic [SET_W-1:0]  last_idx;
    logic [WAYS_MAX-1:0] mask_org0, mask_org1;

    for (genvar w = 0; w < WAYS_MAX; w++) begin : g_way
        assign mask_org0[w] = (w < WAYS_ORG0);
        assign mask_org1[w] = (w < WAYS_ORG1);
    end

    assign last_idx = org ? SET_W'(SETS_ORG1 - 1) : SET_W'(SETS_ORG0 - 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_d = ST_WALK;
                    idx_d   = '0;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WALK: begin
                if (abort_in) begin
                    state_d = ST_IDLE;
                end else if (idx_q == last_idx) begin
                    state_d = ST_DONE;
                end else begin
                    idx_d = SET_W'(idx_q + 1'b1);
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        abort_hit = 1'b0;
        tag_we    = 1'b0;
        tag_set   = idx_q;
        tag_mask  = org ? mask_org1 : mask_org0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_WALK: begin
                busy      = 1'b1;
                abort_hit = abort_in;
                tag_we    = !abort_in;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
    end

    AST_FIRST_SET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (tag_set == '0)); // R2

    AST_SET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_we && $past(tag_we)) |-> (tag_set == SET_W'($past(tag_set) + 1'b1))); // R3

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(tag_we) && ($past(tag_set) == last_idx))); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_NO_WRITE_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        abort_in |-> !tag_we); // R7

    AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_hit |=> (!done && !busy)); // R7

endmodule

// File: rtl/cache_inval_ctrl.sv
`timescale 1ns/1ps
module cache_inval_ctrl
    import cinv_pkg::*;
#(
    parameter int SETS_ORG0 = 128,
    parameter int WAYS_ORG0 = 8,
    parameter int SETS_ORG1 = 256,
    parameter int WAYS_ORG1 = 4
)(
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        wr_en,
    input  logic [CTRL_W-1:0]                           wr_data,
    output logic [CTRL_W-1:0]                           rd_data,
    input  logic                                        abort_in,
    output logic                                        lookup_en,
    output logic                                        busy,
    output logic                                        done,
    output logic                                        tag_we,
    output logic [$clog2((SETS_ORG0 > SETS_ORG1) ? SETS_ORG0 : SETS_ORG1)-1:0] tag_set,
    output logic [((WAYS_ORG0 > WAYS_ORG1) ? WAYS_ORG0 : WAYS_ORG1)-1:0]        tag_mask
);

    logic en_q;
    logic org_q;
    logic abort_q;
    logic start;
    logic abort_hit;

    cinv_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .busy      (busy),
        .abort_hit (abort_hit),
        .en_q      (en_q),
        .org_q     (org_q),
        .abort_q   (abort_q),
        .start     (start),
        .rd_data   (rd_data)
    );

    cinv_walker #(
        .SETS_ORG0 (SETS_ORG0),
        .WAYS_ORG0 (WAYS_ORG0),
        .SETS_ORG1 (SETS_ORG1),
        .WAYS_ORG1 (WAYS_ORG1)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .org       (org_q),
        .abort_in  (abort_in),
        .busy      (busy),
        .done      (done),
        .abort_hit (abort_hit),
        .tag_we    (tag_we),
        .tag_set   (tag_set),
        .tag_mask  (tag_mask)
    );

    assign lookup_en = en_q;

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tag_we); // R3

    AST_LOOKUP_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lookup_en == $past(wr_data[F_EN]))); // R9

    AST_IDLE_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_en) |=> $stable(rd_data[F_ABT])); // R10

endmodule

// File: tb/cache_inval_ctrl_tb.sv
`timescale 1ns/1ps
module cache_inval_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [3:0] wr_data;
    logic [3:0] rd_data;
    logic       abort_in;
    logic       lookup_en;
    logic       busy;
    logic       done;
    logic       tag_we;
    logic [7:0] tag_set;
    logic [7:0] tag_mask;

    int checks = 0;
    int errors = 0;

    logic m_en, m_org, m_abt;

    always #2 clk = ~clk;

    cache_inval_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .abort_in  (abort_in),
        .lookup_en (lookup_en),
        .busy      (busy),
        .done      (done),
        .tag_we    (tag_we),
        .tag_set   (tag_set),
        .tag_mask  (tag_mask)
    );

    function automatic logic [3:0] exp_rd(input logic inv);
        return {m_org, m_abt, inv, m_en};
    endfunction

    function automatic logic [7:0] exp_mask(input logic org);
        return org ? 8'h0F : 8'hFF;
    endfunction

    function automatic int exp_sets(input logic org);
        return org ? 256 : 128;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        m_en = d[0];
        if (!d[2]) m_abt = 1'b0;
        if (!busy) m_org = d[3];
    endtask

    // noise: 0 none, 1 sparse random writes, 2 write every cycle with start set and org flipped
    task automatic do_walk(input logic org, input logic en, input int noise, input int abort_at);
        int n;
        logic [3:0] d;
        n = exp_sets(org);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {org, 1'b0, 1'b1, en};
        m_en = en; m_org = org; m_abt = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en    = 1'b0;
            abort_in = 1'b0;
            if (i == 0) begin
                chk("R2", "busy/start bit", {30'd0, busy, rd_data[1]}, 32'h3);
            end
            chk("R3", "we/set/mask", {15'd0, tag_we, tag_set, tag_mask},
                {15'd0, 1'b1, 8'(i), exp_mask(org)});
            chk("R9", "lookup_en", lookup_en, m_en);
            if (i == abort_at) begin
                abort_in = 1'b1;
                #1;
                chk("R7", "we during abort", tag_we, 1'b0);
                @(negedge clk);
                abort_in = 1'b0;
                m_abt = 1'b1;
                chk("R7", "busy/done after abort", {busy, done}, 2'b00);
                chk("R7", "ctrl after abort", rd_data, exp_rd(1'b0));
                return;
            end
            if (noise == 2) begin
                d = 4'($urandom);
                d[1] = 1'b1;
                d[3] = ~org;
                wr_en = 1'b1; wr_data = d;
                m_en = d[0];
                if (!d[2]) m_abt = 1'b0;
            end else if (noise == 1 && ($urandom % 4) == 0) begin
                d = 4'($urandom);
                wr_en = 1'b1; wr_data = d;
                m_en = d[0];
                if (!d[2]) m_abt = 1'b0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        chk("R4", "done/we/busy at end", {done, tag_we, busy}, 3'b100);
        chk("R4", "ctrl after walk", rd_data, exp_rd(1'b0));
        chk("R6", "org held", rd_data[3], org);
        @(negedge clk);
        chk("R4", "done one cycle", done, 1'b0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; abort_in = 1'b0;
        m_en = 1'b0; m_org = 1'b0; m_abt = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "in reset", {rd_data, busy, done, tag_we, lookup_en}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "after reset", {rd_data, busy, done, tag_we, lookup_en}, 8'h00);

        // R10: abort while idle
        @(negedge clk); abort_in = 1'b1;
        @(negedge clk); abort_in = 1'b0;
        chk("R10", "idle abort", rd_data, 4'h0);

        // R6 / R9: idle writes of org and enable
        wr(4'b1001);
        chk("R9", "lookup_en set", lookup_en, 1'b1);
        chk("R6", "org idle write", rd_data, exp_rd(1'b0));
        wr(4'b0000);
        chk("R9", "lookup_en clear", lookup_en, 1'b0);

        do_walk(1'b0, 1'b0, 0, -1);          // R9 walk with lookups off
        do_walk(1'b1, 1'b1, 0, -1);
        do_walk(1'b0, 1'b1, 2, -1);          // R5 and R6 flood
        do_walk(1'b1, 1'b0, 2, -1);

        // R7 mid-walk abort, then R8
        do_walk(1'b0, 1'b1, 0, 10);
        wr(4'b0101);
        chk("R8", "flag kept on write of 1", rd_data, exp_rd(1'b0));
        wr(4'b0001);
        chk("R8", "flag cleared by write of 0", rd_data, exp_rd(1'b0));

        // R7 abort on the last set
        do_walk(1'b1, 1'b0, 0, 255);
        chk("R7", "abort flag on last set", rd_data[2], 1'b1);
        wr(4'b0000);
        chk("R8", "flag cleared", rd_data[2], 1'b0);

        for (int k = 0; k < 4; k++) begin
            do_walk(1'($urandom % 2), 1'($urandom % 2), 1, -1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule